// File: doc/BRIEF.md
# Three-Channel Absolute/Relative Symbol-Time Compare Unit

This block watches a free-running 32-bit symbol counter that arrives from outside. It has three compare channels, and each one raises an event flag when the counter reaches that channel's target. A mode bit chooses the target for each channel separately. An absolute channel targets its compare register directly. A relative channel targets the sum of its compare register and an externally captured beacon timestamp. This lets software schedule events at a fixed offset after a received beacon.

Event flags are set whether or not the channel is masked. One interrupt output combines every flag whose mask bit is set. Software can drop a flag in two ways: by writing one to its status bit, or by pulsing that channel's acknowledge line when the handler is entered. A relative channel is inert while its offset does not exceed the beacon length, which also arrives from outside. Matching is edge based. A channel reacts only in a cycle where the counter value has just changed, so a stalled counter raises a flag once. A rewritten compare value or mode bit takes effect at the next counter change.

Each channel's flag is held by a two-state machine. The state FLAG_IDLE means no event is pending. The state FLAG_PEND means an event is pending. The transitions are as follows:
- FLAG_IDLE moves to FLAG_PEND on a hit.
- FLAG_PEND stays in FLAG_PEND on a hit, even when a clear arrives in the same cycle.
- FLAG_PEND moves to FLAG_IDLE on a clear without a hit.
- With no hit, FLAG_IDLE stays in FLAG_IDLE.

Top module: `symtick_compare`

## Requirements
- R1: Each of the three channels is independent. In absolute mode, channel i sets its flag at the first clock edge after the counter input changes to a value equal to its compare register.
- R2: In relative mode, channel i matches when the counter equals its compare register plus the beacon timestamp. This sum is taken modulo 2^32 and wraps.
- R3: The mode register is at address 0. Bit i set to 1 selects relative mode for channel i, and 0 selects absolute mode. Each channel's mode is chosen on its own.
- R4: A relative-mode channel never sets its flag while its compare value is less than or equal to the beacon length input.
- R5: A flag is set on a match regardless of its mask bit.
- R6: The mask register is at address 1, with bit i enabling channel i. irq_o is high exactly when some flag is set together with its mask bit.
- R7: The status register is at address 2, with bit i holding channel i's flag. Writing 1 to a status bit clears that flag, and writing 0 leaves it unchanged.
- R8: A high level on irq_ack_i[i] for one clock edge clears channel i's flag.
- R9: When a clear (by write or by acknowledge) and a new match reach the same channel in the same cycle, the flag ends up set.
- R10: A counter that holds its value does not set a flag again. Writing a compare value equal to the current count does not set a flag until the counter changes.
- R11: After reset the mode, mask, status and compare registers all read 0, and irq_o is 0.
- R12: Compare register i is read and written at address 4+i. Reads are combinational from reg_addr_i. Unused addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sym_cnt_i | input | 32 | Free-running symbol counter value |
| bcn_stamp_i | input | 32 | Captured beacon timestamp |
| bcn_len_i | input | 16 | Beacon length in symbols |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data (combinational) |
| irq_ack_i | input | 3 | Per-channel handler-entry acknowledge |
| irq_o | output | 1 | Combined masked interrupt |

## Verification
When the counter input changes in a cycle, the matching flag and irq_o appear after the next rising edge. A register write or an acknowledge takes effect at the same edge that samples it. Register reads follow reg_addr_i within the same cycle. The driver changes inputs on the falling edge and queues each expected status/interrupt pair for the following cycle. The monitor compares that pair 3 ns after the rising edge, when the address has already been returned to the status register. Register reads are compared 1 ns after the falling edge on which the address is set.

// File: rtl/symtick_cmp_pkg.sv
package symtick_cmp_pkg;

    localparam int unsigned REG_AW = 3;

    localparam logic [REG_AW-1:0] A_MODE = 3'd0;
    localparam logic [REG_AW-1:0] A_MASK = 3'd1;
    localparam logic [REG_AW-1:0] A_STAT = 3'd2;
    localparam int unsigned       A_CMP0 = 4;

    typedef enum logic {
        FLAG_IDLE = 1'b0,
        FLAG_PEND = 1'b1
    } flag_state_e;

endpackage

// File: rtl/cmp_target.sv
module cmp_target #(
    parameter int unsigned CNT_W = 32,
    parameter int unsigned LEN_W = 16
) (
    input  logic [CNT_W-1:0] cnt_now,
    input  logic [CNT_W-1:0] cnt_prev,
    input  logic [CNT_W-1:0] cmp_val,
    input  logic [CNT_W-1:0] stamp,
    input  logic [LEN_W-1:0] blen,
    input  logic             rel,
    output logic             hit
);

    logic [CNT_W-1:0] target;
    logic             moved;
    logic             allowed;

    always_comb begin
        target  = rel ? (stamp + cmp_val) : cmp_val;
        moved   = (cnt_now != cnt_prev);
        allowed = !rel || (cmp_val > CNT_W'(blen));
        hit     = moved && allowed && (cnt_now == target);
    end

endmodule

// File: rtl/cmp_flag_fsm.sv
module cmp_flag_fsm
    import symtick_cmp_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic hit,
    input  logic clr,
    output logic flag
);

    flag_state_e state_q;
    flag_state_e state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= FLAG_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FLAG_IDLE: if (hit) state_d = FLAG_PEND;
            FLAG_PEND: if (clr && !hit) state_d = FLAG_IDLE;
        endcase
    end

    always_comb begin
        flag = (state_q == FLAG_PEND);
    end

endmodule

// File: rtl/cmp_regs.sv
module cmp_regs
    import symtick_cmp_pkg::*;
#(
    parameter int unsigned NCH   = 3,
    parameter int unsigned CNT_W = 32
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      we,
    input  logic [REG_AW-1:0]         addr,
    input  logic [CNT_W-1:0]          wdata,
    input  logic [NCH-1:0]            status,
    output logic [NCH-1:0]            mode,
    output logic [NCH-1:0]            mask,
    output logic [NCH-1:0][CNT_W-1:0] cmp,
    output logic [CNT_W-1:0]          rdata
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode <= '0;
            mask <= '0;
            cmp  <= '0;
        end else if (we) begin
            if (addr == A_MODE) mode <= wdata[NCH-1:0];
            if (addr == A_MASK) mask <= wdata[NCH-1:0];
            for (int i = 0; i < NCH; i++) begin
                if (addr == REG_AW'(A_CMP0 + i)) cmp[i] <= wdata;
            end
        end
    end

    always_comb begin
        rdata = '0;
        if (addr == A_MODE) rdata = {{(CNT_W-NCH){1'b0}}, mode};
        if (addr == A_MASK) rdata = {{(CNT_W-NCH){1'b0}}, mask};
        if (addr == A_STAT) rdata = {{(CNT_W-NCH){1'b0}}, status};
        for (int i = 0; i < NCH; i++) begin
            if (addr == REG_AW'(A_CMP0 + i)) rdata = cmp[i];
        end
    end

endmodule

// File: rtl/symtick_compare.sv
module symtick_compare
    import symtick_cmp_pkg::*;
#(
    parameter int unsigned NCH   = 3,
    parameter int unsigned CNT_W = 32,
    parameter int unsigned LEN_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CNT_W-1:0]  sym_cnt_i,
    input  logic [CNT_W-1:0]  bcn_stamp_i,
    input  logic [LEN_W-1:0]  bcn_len_i,
    input  logic              reg_we_i,
    input  logic [REG_AW-1:0] reg_addr_i,
    input  logic [CNT_W-1:0]  reg_wdata_i,
    output logic [CNT_W-1:0]  reg_rdata_o,
    input  logic [NCH-1:0]    irq_ack_i,
    output logic              irq_o
);

    logic [CNT_W-1:0]            cnt_q;
    logic [NCH-1:0]              mode_w;
    logic [NCH-1:0]              mask_w;
    logic [NCH-1:0][CNT_W-1:0]   cmp_w;
    logic [NCH-1:0]              hit_w;
    logic [NCH-1:0]              flag_w;
    logic [NCH-1:0]              clr_w;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= sym_cnt_i;
        end
    end

    always_comb begin
        clr_w = irq_ack_i;
        if (reg_we_i && reg_addr_i == A_STAT) clr_w = clr_w | reg_wdata_i[NCH-1:0];
    end

    cmp_regs #(.NCH(NCH), .CNT_W(CNT_W)) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (reg_we_i),
        .addr   (reg_addr_i),
        .wdata  (reg_wdata_i),
        .status (flag_w),
        .mode   (mode_w),
        .mask   (mask_w),
        .cmp    (cmp_w),
        .rdata  (reg_rdata_o)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        cmp_target #(.CNT_W(CNT_W), .LEN_W(LEN_W)) u_tgt (
            .cnt_now  (sym_cnt_i),
            .cnt_prev (cnt_q),
            .cmp_val  (cmp_w[g]),
            .stamp    (bcn_stamp_i),
            .blen     (bcn_len_i),
            .rel      (mode_w[g]),
            .hit      (hit_w[g])
        );

        cmp_flag_fsm u_fsm (
            .clk   (clk),
            .rst_n (rst_n),
            .hit   (hit_w[g]),
            .clr   (clr_w[g]),
            .flag  (flag_w[g])
        );
    end

    always_comb begin
        irq_o = |(flag_w & mask_w);
    end

endmodule

// File: rtl/symtick_compare_chk.sv
module symtick_compare_chk #(
    parameter int unsigned NCH   = 3,
    parameter int unsigned CNT_W = 32,
    parameter int unsigned LEN_W = 16
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic [CNT_W-1:0]          cnt_i,
    input logic [CNT_W-1:0]          cnt_q,
    input logic [NCH-1:0]            hit,
    input logic [NCH-1:0]            flag,
    input logic [NCH-1:0]            mask,
    input logic [NCH-1:0]            mode,
    input logic [NCH-1:0][CNT_W-1:0] cmp,
    input logic [LEN_W-1:0]          blen,
    input logic                      irq_o
);

    AST_HIT_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (|hit) |=> ((flag & $past(hit)) == $past(hit))); // R9

    AST_NO_SPONTANEOUS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((flag & ~$past(flag) & ~$past(hit)) == '0)); // R1

    AST_HELD_COUNT_NO_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_i == cnt_q) |-> (hit == '0)); // R10

    AST_MASKED_NO_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        (mask == '0) |-> !irq_o); // R6

    AST_PENDING_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        ((flag & mask) != '0) |-> irq_o); // R6

    for (genvar g = 0; g < NCH; g++) begin : g_rel
        AST_REL_SHORT_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
            (mode[g] && cmp[g] <= CNT_W'(blen)) |-> !hit[g]); // R4
    end

endmodule

bind symtick_compare symtick_compare_chk #(.NCH(NCH), .CNT_W(CNT_W), .LEN_W(LEN_W)) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .cnt_i (sym_cnt_i),
    .cnt_q (cnt_q),
    .hit   (hit_w),
    .flag  (flag_w),
    .mask  (mask_w),
    .mode  (mode_w),
    .cmp   (cmp_w),
    .blen  (bcn_len_i),
    .irq_o (irq_o)
);

// File: tb/tb_symtick_compare.sv
module tb_symtick_compare;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [31:0] cnt;
    logic [31:0] stamp;
    logic [15:0] blen;
    logic        we;
    logic [2:0]  addr;
    logic [31:0] wdata;
    logic [31:0] rdata;
    logic [2:0]  ack;
    logic        irq;

    int checks = 0;
    int errors = 0;
    int cyc    = 0;
    bit done   = 1'b0;

    typedef struct {
        int         due;
        logic [2:0] st;
        logic       irq;
        string      req;
    } item_t;

    item_t exp_q[$];

    always #4 clk = ~clk;

    symtick_compare dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .sym_cnt_i   (cnt),
        .bcn_stamp_i (stamp),
        .bcn_len_i   (blen),
        .reg_we_i    (we),
        .reg_addr_i  (addr),
        .reg_wdata_i (wdata),
        .reg_rdata_o (rdata),
        .irq_ack_i   (ack),
        .irq_o       (irq)
    );

    // monitor: pops queued expectations, samples 3 ns after the rising edge
    always @(posedge clk) begin
        cyc = cyc + 1;
        #3;
        while (exp_q.size() > 0 && exp_q[0].due <= cyc) begin
            item_t it;
            it = exp_q.pop_front();
            checks++;
            if (rdata[2:0] !== it.st || irq !== it.irq) begin
                errors++;
                $display("FAIL %s: status=%b irq=%b expected status=%b irq=%b",
                         it.req, rdata[2:0], irq, it.st, it.irq);
            end
        end
    end

    task automatic expect_next(input logic [2:0] st, input logic ir, input string req);
        item_t it;
        it.due = cyc + 1;
        it.st  = st;
        it.irq = ir;
        it.req = req;
        exp_q.push_back(it);
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        addr = a; wdata = d; we = 1'b1;
        @(posedge clk);
        #1;
        we = 1'b0; addr = 3'd2;
    endtask

    task automatic step(input logic [31:0] v);
        @(negedge clk);
        cnt = v;
    endtask

    task automatic pulse_ack(input logic [2:0] v);
        @(negedge clk);
        ack = v;
        @(posedge clk);
        #1;
        ack = '0;
    endtask

    task automatic rd_check(input logic [2:0] a, input logic [31:0] e, input string req);
        @(negedge clk);
        addr = a;
        #1;
        checks++;
        if (rdata !== e) begin
            errors++;
            $display("FAIL %s: addr %0d read %h expected %h", req, a, rdata, e);
        end
        addr = 3'd2;
    endtask

    task automatic settle();
        @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        rst_n = 1'b0; cnt = '0; stamp = '0; blen = '0;
        we = 1'b0; addr = 3'd2; wdata = '0; ack = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R11 reset state
        expect_next(3'b000, 1'b0, "R11 status/irq");
        settle();
        rd_check(3'd0, 32'd0, "R11 mode");
        rd_check(3'd1, 32'd0, "R11 mask");
        rd_check(3'd4, 32'd0, "R11 cmp0");

        // R1 / R5 absolute hit with mask off
        wr(3'd4, 32'd10);
        step(32'd9);  expect_next(3'b000, 1'b0, "R1 below target");
        step(32'd10); expect_next(3'b001, 1'b0, "R1 R5 absolute hit unmasked");
        settle();
        // R7 write-one clear, R10 held counter
        wr(3'd2, 32'd1); expect_next(3'b000, 1'b0, "R7 w1c");
        settle();
        step(32'd10); expect_next(3'b000, 1'b0, "R10 held counter");
        settle();
        rd_check(3'd4, 32'd10, "R12 cmp0 readback");
        rd_check(3'd3, 32'd0, "R12 unused addr");

        // R6 masked interrupt, R8 acknowledge
        wr(3'd1, 32'd1);
        wr(3'd4, 32'd12);
        step(32'd11); expect_next(3'b000, 1'b0, "R6 no hit");
        step(32'd12); expect_next(3'b001, 1'b1, "R6 irq when masked-in flag");
        settle();
        pulse_ack(3'b001); expect_next(3'b000, 1'b0, "R8 ack clears");
        settle();
        // R10 rewriting compare to the current count does not fire
        wr(3'd4, 32'd12); expect_next(3'b000, 1'b0, "R10 compare write equal count");
        settle();

        // R2 / R3 relative mode on ch1, absolute ch2, same instant
        stamp = 32'd1000; blen = 16'd20;
        wr(3'd0, 32'b010);
        rd_check(3'd0, 32'd2, "R3 mode readback");
        wr(3'd5, 32'd50);
        wr(3'd6, 32'd1050);
        rd_check(3'd6, 32'd1050, "R12 cmp2 readback");
        step(32'd1049); expect_next(3'b000, 1'b0, "R2 before relative target");
        step(32'd1050); expect_next(3'b110, 1'b0, "R2 R1 relative and absolute together");
        settle();
        wr(3'd2, 32'd6); expect_next(3'b000, 1'b0, "R7 w1c two bits");
        settle();

        // R4 relative offset not above beacon length
        wr(3'd5, 32'd20);
        step(32'd1020); expect_next(3'b000, 1'b0, "R4 offset equal length blocked");
        settle();
        wr(3'd5, 32'd21);
        step(32'd1021); expect_next(3'b010, 1'b0, "R4 offset above length fires");
        settle();
        wr(3'd2, 32'd2);

        // R2 wrap of relative target
        stamp = 32'hFFFF_FFF0;
        wr(3'd0, 32'b011);
        wr(3'd4, 32'h30);
        step(32'h1F); expect_next(3'b000, 1'b0, "R2 wrap before");
        step(32'h20); expect_next(3'b001, 1'b1, "R2 wrapped target hit");
        settle();
        pulse_ack(3'b001); expect_next(3'b000, 1'b0, "R8 ack after wrap");
        settle();

        // R9 set wins over write-one clear
        wr(3'd6, 32'h40);
        step(32'h40); expect_next(3'b100, 1'b0, "R1 ch2 hit");
        settle();
        wr(3'd6, 32'h42);
        @(negedge clk);
        cnt = 32'h42; addr = 3'd2; wdata = 32'd4; we = 1'b1;
        expect_next(3'b100, 1'b0, "R9 set wins over clear");
        @(posedge clk);
        #1;
        we = 1'b0;
        settle();
        // R9 set wins over acknowledge
        wr(3'd6, 32'h43);
        @(negedge clk);
        cnt = 32'h43; ack = 3'b100;
        expect_next(3'b100, 1'b0, "R9 set wins over ack");
        @(posedge clk);
        #1;
        ack = '0;
        settle();
        wr(3'd2, 32'd4); expect_next(3'b000, 1'b0, "R7 final clear");

        repeat (4) @(negedge clk);
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: run did not finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule